// File: doc/BRIEF.md
# Stereo Transmit Buffer Status Controller

This block keeps the host-side bookkeeping for up to three parallel stereo serial transmitters that share one left/right word clock. Each transmitter has a holding register that the host fills over a simple write port. The serial side signals a transfer with a single strobe and a flag that says whether the word now leaving the holding registers is a left or a right sample. The block hands the held words to the shift side, keeps two status flags (left-empty and right-empty) that tell the host which channel to load next, raises an interrupt request, and flags an underrun when the host falls behind.

A state machine follows the transmitters' life cycle. The states are ST_IDLE (every transmitter disabled), ST_SYNC (enabled, waiting for the first left slot) and ST_RUN (words are transferred on every strobe). Its transitions are: IDLE→SYNC when any enable is set; SYNC→RUN on the first strobe in a left slot; and SYNC/RUN→IDLE on a software reset, the stop state, or all enables cleared. Entering SYNC sets left-empty, so the host loads left words first. When both empty flags are set at once, the host has missed a word. The old holding-register contents are then sent again, and the flags clear only after a status read followed by a complete write.

Top module: `stx_status_ctrl`

## Requirements
- R1: After hardware reset both empty flags, `irq_req`, `irq_underrun`, `shift_load` and `shift_word` are 0.
- R2: One cycle after any enable is set while all were clear, left-empty is 1 and right-empty is 0. Until the first strobe with `take_left`=1, strobes with `take_left`=0 are ignored: no `shift_load`, and the flags do not change.
- R3: An accepted strobe with `take_left`=1 sets right-empty in the next cycle. In that same cycle `shift_load` is 1 for one cycle, and `shift_word[i*24 +: 24]` holds transmitter i's holding register.
- R4: An accepted strobe with `take_left`=0 sets left-empty in the next cycle, with the same load behaviour as R3.
- R5: Without underrun, a write group clears the set empty flag in the cycle after the write that completes it. A group is complete once every enabled transmitter's holding register has been written since the last transfer. Earlier writes in the group leave the flags unchanged.
- R6: Disabled transmitters take no part in group completion. Writes to them change no flag, and their lane of `shift_word` is 0 on a load.
- R7: A strobe that arrives while the opposite flag is still set leaves both flags at 1 (underrun), and `irq_underrun` is then 1. The loaded words are the unchanged old holding contents.
- R8: During underrun, a completed write group clears both flags only if a status read (`stat_rd`) came before it since the last completed group. Without that read, both flags stay at 1.
- R9: `irq_req` is 1 exactly when `irq_en` is 1 and at least one empty flag is set. `irq_underrun` selects the underrun vector and is 1 when both flags are set.
- R10: `soft_rst`, `stop_mode`, or all enables at 0 clears both flags in the next cycle. The block then returns to ST_IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| soft_rst | input | 1 | Synchronous software reset of status and state |
| stop_mode | input | 1 | Stop state; clears status like a reset |
| tx_en | input | NUM_TX | Per-transmitter enable |
| irq_en | input | 1 | Transmit interrupt enable |
| stat_rd | input | 1 | Pulse: host read of the status register |
| wr_en | input | 1 | Pulse: host write to a holding register |
| wr_sel | input | SEL_W | Index of the holding register written |
| wr_data | input | DATA_W | Write data |
| take_strobe | input | 1 | Serial side moves words to the shift registers |
| take_left | input | 1 | Slot of the strobe: 1 left, 0 right |
| left_empty | output | 1 | Host should load left words |
| right_empty | output | 1 | Host should load right words |
| irq_req | output | 1 | Interrupt request |
| irq_underrun | output | 1 | Interrupt vector select: 1 underrun, 0 normal |
| shift_load | output | 1 | One-cycle pulse: `shift_word` is valid |
| shift_word | output | NUM_TX*DATA_W | Words handed to the shift registers, lane i for transmitter i |

## Verification
A stale written-mask or a lost read arm shows one cycle after the completing write. Either the flag that should clear stays up, or an underrun clears without the read that must come first. A wrong state shows at the first strobe after enabling, as a load in a right slot or a missing load in a left slot. The bench sweeps every non-zero enable mask, with the interrupt enable toggled between masks. For each mask it runs enable, sync, partial and complete groups, underrun with stale resend, and both clearing paths.

// File: rtl/stx_pkg.sv
package stx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SYNC = 2'd1,
        ST_RUN  = 2'd2
    } stx_state_e;
endpackage

// File: rtl/stx_hold_bank.sv
module stx_hold_bank #(
    parameter int NUM_TX = 3,
    parameter int DATA_W = 24,
    parameter int SEL_W  = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     kill,
    input  logic [NUM_TX-1:0]        tx_en,
    input  logic                     wr_en,
    input  logic [SEL_W-1:0]         wr_sel,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic                     accept,
    output logic                     wr_done,
    output logic                     shift_load,
    output logic [NUM_TX*DATA_W-1:0] shift_word
);
    logic [NUM_TX-1:0] sel_hot;
    logic [NUM_TX-1:0] written_q;
    logic [NUM_TX-1:0] written_n;

    generate
        for (genvar i = 0; i < NUM_TX; i++) begin : g_lane
            logic [DATA_W-1:0] hold_q;
            assign sel_hot[i] = wr_en && (wr_sel == SEL_W'(i));

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    hold_q <= '0;
                end else if (sel_hot[i]) begin
                    hold_q <= wr_data;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    shift_word[i*DATA_W +: DATA_W] <= '0;
                end else if (accept) begin
                    shift_word[i*DATA_W +: DATA_W] <= tx_en[i] ? hold_q : '0;
                end
            end
        end
    endgenerate

    assign written_n = written_q | sel_hot;
    assign wr_done   = wr_en && !kill && (tx_en != '0)
                       && ((written_n & tx_en) == tx_en);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            written_q  <= '0;
            shift_load <= 1'b0;
        end else begin
            shift_load <= accept;
            if (kill || accept || wr_done) begin
                written_q <= '0;
            end else begin
                written_q <= written_n;
            end
        end
    end
endmodule

// File: rtl/stx_flag_ctrl.sv
module stx_flag_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic kill,
    input  logic enter_sync,
    input  logic accept,
    input  logic acc_left,
    input  logic wr_done,
    input  logic stat_rd,
    output logic left_empty,
    output logic right_empty,
    output logic rd_armed
);
    logic both;
    logic clr;

    assign both = left_empty && right_empty;
    assign clr  = wr_done && (!both || rd_armed);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_empty  <= 1'b0;
            right_empty <= 1'b0;
            rd_armed    <= 1'b0;
        end else if (kill) begin
            left_empty  <= 1'b0;
            right_empty <= 1'b0;
            rd_armed    <= 1'b0;
        end else begin
            left_empty  <= (left_empty && !clr) || (accept && !acc_left) || enter_sync;
            right_empty <= (right_empty && !clr) || (accept && acc_left);
            rd_armed    <= stat_rd || (rd_armed && !wr_done);
        end
    end
endmodule

// File: rtl/stx_status_ctrl.sv
module stx_status_ctrl
    import stx_pkg::*;
#(
    parameter int NUM_TX = 3,
    parameter int DATA_W = 24,
    parameter int SEL_W  = (NUM_TX > 1) ? $clog2(NUM_TX) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     soft_rst,
    input  logic                     stop_mode,
    input  logic [NUM_TX-1:0]        tx_en,
    input  logic                     irq_en,
    input  logic                     stat_rd,
    input  logic                     wr_en,
    input  logic [SEL_W-1:0]         wr_sel,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic                     take_strobe,
    input  logic                     take_left,
    output logic                     left_empty,
    output logic                     right_empty,
    output logic                     irq_req,
    output logic                     irq_underrun,
    output logic                     shift_load,
    output logic [NUM_TX*DATA_W-1:0] shift_word
);
    stx_state_e state_q;
    stx_state_e state_n;
    logic       kill;
    logic       accept;
    logic       enter_sync;
    logic       wr_done;
    logic       rd_armed;

    assign kill = soft_rst || stop_mode || (tx_en == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_n;
        end
    end

    always_comb begin
        state_n    = state_q;
        accept     = 1'b0;
        enter_sync = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (!kill) begin
                    state_n    = ST_SYNC;
                    enter_sync = 1'b1;
                end
            end
            ST_SYNC: begin
                if (kill) begin
                    state_n = ST_IDLE;
                end else if (take_strobe && take_left) begin
                    state_n = ST_RUN;
                    accept  = 1'b1;
                end
            end
            ST_RUN: begin
                if (kill) begin
                    state_n = ST_IDLE;
                end else begin
                    accept = take_strobe;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    stx_hold_bank #(
        .NUM_TX(NUM_TX),
        .DATA_W(DATA_W),
        .SEL_W (SEL_W)
    ) bank_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .kill      (kill),
        .tx_en     (tx_en),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .accept    (accept),
        .wr_done   (wr_done),
        .shift_load(shift_load),
        .shift_word(shift_word)
    );

    stx_flag_ctrl flags_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .kill       (kill),
        .enter_sync (enter_sync),
        .accept     (accept),
        .acc_left   (take_left),
        .wr_done    (wr_done),
        .stat_rd    (stat_rd),
        .left_empty (left_empty),
        .right_empty(right_empty),
        .rd_armed   (rd_armed)
    );

    assign irq_req      = irq_en && (left_empty || right_empty);
    assign irq_underrun = left_empty && right_empty;
endmodule

// File: rtl/stx_status_chk.sv
module stx_status_chk #(
    parameter int NUM_TX = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              soft_rst,
    input logic              stop_mode,
    input logic [NUM_TX-1:0] tx_en,
    input logic              irq_en,
    input logic              stat_rd,
    input logic              take_strobe,
    input logic              take_left,
    input logic              left_empty,
    input logic              right_empty,
    input logic              irq_req,
    input logic              shift_load,
    input logic              rd_armed
);
    // R10
    kill_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_rst || stop_mode || tx_en == '0) |=> (!left_empty && !right_empty));

    // R3
    rse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(right_empty) |-> $past(take_strobe && take_left));

    // R3
    load_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_load |-> $past(take_strobe));

    // R8
    ur_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (left_empty && right_empty && !rd_armed && !stat_rd && !soft_rst
         && !stop_mode && tx_en != '0) |=> (left_empty && right_empty));

    // R9
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(right_empty) && irq_en) |-> irq_req);
endmodule

bind stx_status_ctrl stx_status_chk #(.NUM_TX(NUM_TX)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst   (soft_rst),
    .stop_mode  (stop_mode),
    .tx_en      (tx_en),
    .irq_en     (irq_en),
    .stat_rd    (stat_rd),
    .take_strobe(take_strobe),
    .take_left  (take_left),
    .left_empty (left_empty),
    .right_empty(right_empty),
    .irq_req    (irq_req),
    .shift_load (shift_load),
    .rd_armed   (rd_armed)
);

// File: tb/stx_status_ctrl_tb.sv
module stx_status_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NT = 3;
    localparam int DW = 24;
    localparam int SW = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             soft_rst = 1'b0;
    logic             stop_mode = 1'b0;
    logic [NT-1:0]    tx_en = '0;
    logic             irq_en = 1'b0;
    logic             stat_rd = 1'b0;
    logic             wr_en = 1'b0;
    logic [SW-1:0]    wr_sel = '0;
    logic [DW-1:0]    wr_data = '0;
    logic             take_strobe = 1'b0;
    logic             take_left = 1'b0;
    logic             left_empty;
    logic             right_empty;
    logic             irq_req;
    logic             irq_underrun;
    logic             shift_load;
    logic [NT*DW-1:0] shift_word;

    int errs = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stx_status_ctrl #(.NUM_TX(NT), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .stop_mode(stop_mode),
        .tx_en(tx_en), .irq_en(irq_en), .stat_rd(stat_rd), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .take_strobe(take_strobe),
        .take_left(take_left), .left_empty(left_empty), .right_empty(right_empty),
        .irq_req(irq_req), .irq_underrun(irq_underrun), .shift_load(shift_load),
        .shift_word(shift_word)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [DW-1:0] dat(input int m, input int i, input int k);
        return DW'(m * 65536 + i * 256 + k);
    endfunction

    function automatic logic [NT*DW-1:0] exp_word(input int m, input int k);
        logic [NT*DW-1:0] w = '0;
        for (int i = 0; i < NT; i++) begin
            if (m[i]) w[i*DW +: DW] = dat(m, i, k);
        end
        return w;
    endfunction

    task automatic chk_flags(input logic le_e, input logic re_e, input string req);
        logic irq_e = irq_en && (le_e || re_e);
        logic vec_e = le_e && re_e;
        checks++;
        if (left_empty !== le_e || right_empty !== re_e || irq_req !== irq_e
            || irq_underrun !== vec_e) begin
            errs++;
            $display("FAIL %s: le/re/irq/vec got %b%b%b%b exp %b%b%b%b", req,
                     left_empty, right_empty, irq_req, irq_underrun,
                     le_e, re_e, irq_e, vec_e);
        end
    endtask

    task automatic chk_load(input logic ld_e, input logic [NT*DW-1:0] w_e, input string req);
        checks++;
        if (shift_load !== ld_e || (ld_e && shift_word !== w_e)) begin
            errs++;
            $display("FAIL %s: load/word got %b/%h exp %b/%h", req,
                     shift_load, shift_word, ld_e, w_e);
        end
    endtask

    task automatic do_take(input logic left);
        take_strobe = 1'b1;
        take_left   = left;
        tick();
        take_strobe = 1'b0;
    endtask

    task automatic do_write(input int i, input logic [DW-1:0] d);
        wr_en   = 1'b1;
        wr_sel  = SW'(i);
        wr_data = d;
        tick();
        wr_en   = 1'b0;
    endtask

    task automatic do_read();
        stat_rd = 1'b1;
        tick();
        stat_rd = 1'b0;
    endtask

    task automatic wr_all(input int m, input int k);
        for (int i = 0; i < NT; i++) begin
            if (m[i]) do_write(i, dat(m, i, k));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog: run did not end, got timeout exp completion");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk_flags(1'b0, 1'b0, "R1 reset flags");
        chk_load(1'b0, '0, "R1 reset load");
        checks++;
        if (shift_word !== '0) begin
            errs++;
            $display("FAIL R1: shift_word got %h exp 0", shift_word);
        end

        for (int m = 1; m < (1 << NT); m++) begin
            int last = 0;
            for (int i = 0; i < NT; i++) if (m[i]) last = i;
            irq_en = m[0];
            tx_en = '0;
            tick();
            chk_flags(1'b0, 1'b0, "R10 all disabled");
            tx_en = NT'(m);
            tick();
            chk_flags(1'b1, 1'b0, "R2 enable sets left-empty");
            do_take(1'b0);
            chk_load(1'b0, '0, "R2 right slot ignored in sync");
            chk_flags(1'b1, 1'b0, "R2 flags unchanged in sync");
            for (int i = 0; i < NT; i++) begin
                if (!m[i]) do_write(i, 24'hABCDEF);
            end
            chk_flags(1'b1, 1'b0, "R6 disabled writes ignored");
            for (int i = 0; i < NT; i++) begin
                if (m[i]) begin
                    do_write(i, dat(m, i, 1));
                    chk_flags(i != last, 1'b0, "R5 group completion");
                end
            end
            do_take(1'b1);
            chk_load(1'b1, exp_word(m, 1), "R3 R6 left words loaded");
            chk_flags(1'b0, 1'b1, "R3 left transfer sets right-empty");
            do_take(1'b0);
            chk_flags(1'b1, 1'b1, "R7 underrun");
            chk_load(1'b1, exp_word(m, 1), "R7 stale resend");
            wr_all(m, 2);
            chk_flags(1'b1, 1'b1, "R8 write without read");
            do_read();
            wr_all(m, 3);
            chk_flags(1'b0, 1'b0, "R8 read then write clears");
            do_take(1'b1);
            chk_flags(1'b0, 1'b1, "R3 left transfer after recovery");
            chk_load(1'b1, exp_word(m, 3), "R3 new words loaded");
            wr_all(m, 4);
            chk_flags(1'b0, 1'b0, "R5 right group clears");
            do_take(1'b0);
            chk_flags(1'b1, 1'b0, "R4 right transfer sets left-empty");
            chk_load(1'b1, exp_word(m, 4), "R4 right words loaded");
            soft_rst = 1'b1;
            tick();
            soft_rst = 1'b0;
            chk_flags(1'b0, 1'b0, "R10 soft reset");
            tick();
            chk_flags(1'b1, 1'b0, "R2 re-sync after soft reset");
            stop_mode = 1'b1;
            tick();
            stop_mode = 1'b0;
            chk_flags(1'b0, 1'b0, "R10 stop state");
            tick();
            chk_flags(1'b1, 1'b0, "R2 re-sync after stop");
        end

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule